// File: doc/BRIEF.md
# Run-Time Addressable Delay Line

This block delays a single-bit stream by a number of clock-enabled cycles chosen at run time. Each unit is a chain of sixteen storage stages. Every enabled clock edge moves the data one stage further along. An address picks which stage feeds the output. A typical use is to pad a short datapath so that its latency matches that of a longer parallel pipeline. Because the address is sampled every cycle, the padding can be retuned while data flows.

Units chain end to end. The last stage of one unit feeds the first stage of the next, so the top level offers one flat delay range of sixteen times the unit count. The low four address bits select a stage within a unit, and the upper bits select the unit. The last stage of the whole chain is always available on a separate pin, whatever the address, for further extension outside the block.

An optional output flip-flop (parameter `OUT_REG`) sits after the stage selector. It adds one cycle of depth and shortens the timing path. It is the only state that the synchronous reset touches. The storage stages are never cleared and hold unknown values after power-up.

Top module: `dly_line_chain`

## Requirements
- R1: Let `a` be the value on `addr`, from 0 to 16*N_UNITS-1. Without the output register, `dout` shows the `din` value captured a+1 enabled edges earlier. Stage 0 takes `din` on each edge where `ce` is 1.
- R2: While `ce` is 0, no stage changes value. Only edges with `ce` at 1 count towards the delay.
- R3: Without the output register, a change on `addr` shows up on `dout` in the same cycle, with no clock edge needed.
- R4: `cascade_out` shows the `din` value captured 16*N_UNITS enabled edges earlier, whatever the value of `addr`.
- R5: With the output register (`OUT_REG`=1, the default), each enabled edge loads `dout` with the stage that `addr` selected just before that edge. With a steady address this gives a delay of a+2 enabled edges. Without an enabled edge, `dout` holds its value.
- R6: When `rst` is 1 at an edge, the registered `dout` becomes 0, whatever `ce` is. The storage stages are not cleared, and they still shift if `ce` is 1.
- R7: `addr` is ceil(log2(16*N_UNITS)) bits wide. Bits [3:0] select the stage inside a unit. The upper bits select the unit, with unit 0 nearest the input. Address 15 is the last stage of unit 0, and address 16 is the first stage of unit 1.

Parameter `OUT_REG` selects between the two output behaviours: 1 (the default) gives the registered output of R5 and R6, and 0 gives the direct output of R1 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop only |
| ce | input | 1 | Clock enable for every stage and for the output flip-flop |
| din | input | 1 | Serial data in |
| addr | input | AW | Tap address; the delay is the address plus one enabled cycle |
| dout | output | 1 | Data from the addressed stage, registered when `OUT_REG`=1 |
| cascade_out | output | 1 | Last stage of the last unit |

## Verification
The bench sweeps every address and crosses the boundary between units at 15 and 16. A miswired link between units would show up there as a skipped or repeated cycle. It toggles `ce` so that an enable that leaks into the chain or the output flip-flop shows up as a shortened delay. It changes the address with no clock edge, so a selector that samples the address late would be caught. It also checks that `cascade_out` ignores the address. It asserts reset with and without enable, to catch a reset that wipes the stored stages or loses priority over the enable.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int UNIT_DEPTH = 16;
  localparam int UNIT_AW    = $clog2(UNIT_DEPTH);
endpackage

// File: rtl/srl_shift_chain.sv
module srl_shift_chain #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (ce) sr <= {sr[DEPTH-2:0], din};
  end

  assign stages = sr;

  // R1
  head_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> sr[0] === $past(din));
  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> sr[DEPTH-1:1] === $past(sr[DEPTH-2:0]));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sr));
endmodule

// File: rtl/srl_tap_mux.sv
module srl_tap_mux #(
  parameter int DEPTH = 16,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] stages,
  input  logic [TW-1:0]    tap,
  output logic             q
);
  always_comb q = stages[tap];
endmodule

// File: rtl/srl_unit.sv
module srl_unit #(
  parameter int DEPTH = 16,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          din,
  input  logic [TW-1:0] tap,
  output logic          q,
  output logic          cascade
);
  logic [DEPTH-1:0] stages;

  srl_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .din    (din),
    .stages (stages)
  );

  srl_tap_mux #(.DEPTH(DEPTH), .TW(TW)) u_mux (
    .stages (stages),
    .tap    (tap),
    .q      (q)
  );

  assign cascade = stages[DEPTH-1];

  // R4
  cascade_step_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> cascade === $past(stages[DEPTH-2]));
endmodule

// File: rtl/srl_unit_select.sv
module srl_unit_select #(
  parameter int N_UNITS = 2,
  parameter int UW      = 1
) (
  input  logic [N_UNITS-1:0] unit_q,
  input  logic [UW-1:0]      unit_idx,
  input  logic               last,
  output logic               sel
);
  always_comb begin
    if (int'(unit_idx) < N_UNITS) sel = unit_q[unit_idx];
    else                          sel = last;
  end
endmodule

// File: rtl/dly_line_chain.sv
module dly_line_chain import srl_pkg::*; #(
  parameter int N_UNITS = 2,
  parameter bit OUT_REG = 1'b1,
  parameter int AW      = $clog2(UNIT_DEPTH * N_UNITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          din,
  input  logic [AW-1:0] addr,
  output logic          dout,
  output logic          cascade_out
);
  localparam int UW = (AW > UNIT_AW) ? AW - UNIT_AW : 1;

  logic [N_UNITS:0]   link;
  logic [N_UNITS-1:0] unit_q;
  logic [UW-1:0]      uidx;
  logic               sel;

  assign link[0] = din;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    srl_unit #(.DEPTH(UNIT_DEPTH), .TW(UNIT_AW)) u_unit (
      .clk     (clk),
      .rst     (rst),
      .ce      (ce),
      .din     (link[u]),
      .tap     (addr[UNIT_AW-1:0]),
      .q       (unit_q[u]),
      .cascade (link[u+1])
    );
  end

  if (AW > UNIT_AW) begin : g_hi
    assign uidx = addr[AW-1:UNIT_AW];
  end else begin : g_nohi
    assign uidx = '0;
  end

  srl_unit_select #(.N_UNITS(N_UNITS), .UW(UW)) u_sel (
    .unit_q   (unit_q),
    .unit_idx (uidx),
    .last     (link[N_UNITS]),
    .sel      (sel)
  );

  assign cascade_out = link[N_UNITS];

  if (OUT_REG) begin : g_oreg
    logic q_r;
    always_ff @(posedge clk) begin
      if (rst)     q_r <= 1'b0;
      else if (ce) q_r <= sel;
    end
    assign dout = q_r;

    // R6
    out_reset_chk: assert property (@(posedge clk)
      rst |=> dout == 1'b0);
    // R5
    out_load_chk: assert property (@(posedge clk) disable iff (rst)
      ce |=> dout === $past(sel));
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(dout));
  end else begin : g_direct
    assign dout = sel;
  end
endmodule

// File: tb/dly_line_chain_tb.sv
`timescale 1ns/1ps
module dly_line_chain_tb;
  localparam int N   = 2;
  localparam int AW  = 5;
  localparam int TOT = 16 * N;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout_r, casc_r, dout_c, casc_c;

  always #2 clk = ~clk;

  dly_line_chain #(.N_UNITS(N), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .addr(addr),
    .dout(dout_r), .cascade_out(casc_r));

  dly_line_chain #(.N_UNITS(N), .OUT_REG(1'b0)) u_dut_raw (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .addr(addr),
    .dout(dout_c), .cascade_out(casc_c));

  typedef struct {
    bit    chk_c; bit exp_c;
    bit    chk_r; bit exp_r;
    bit    chk_k; bit exp_k;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   hist[$];
  bit   mreg = 1'b0, mreg_known = 1'b0;
  logic [15:0] lf = 16'hACE1;
  int   n_tests = 0, n_fail = 0;

  task automatic chk(bit act, bit exp, string tag, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic bit next_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic step(bit d, bit e, int a, bit r, string tag);
    exp_t it;
    @(negedge clk);
    din = d; ce = e; addr = a[AW-1:0]; rst = r;
    @(posedge clk);
    if (r) begin
      mreg = 1'b0; mreg_known = 1'b1;
    end else if (e) begin
      mreg_known = (hist.size() > a);
      if (mreg_known) mreg = hist[a];
    end
    if (e) begin
      hist.push_front(d);
      if (hist.size() > 40) void'(hist.pop_back());
    end
    it.tag   = tag;
    it.chk_c = (hist.size() > a);
    it.exp_c = it.chk_c ? hist[a] : 1'b0;
    it.chk_r = mreg_known;
    it.exp_r = mreg;
    it.chk_k = (hist.size() >= TOT);
    it.exp_k = it.chk_k ? hist[TOT-1] : 1'b0;
    exp_q.push_back(it);
  endtask

  // R3: address change with no clock edge
  task automatic peek(int a);
    @(negedge clk);
    ce = 1'b0; rst = 1'b0; addr = a[AW-1:0];
    #1;
    chk(dout_c, hist[a], "R3", "direct output after address change");
    if (mreg_known) chk(dout_r, mreg, "R3", "registered output unchanged");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t it;
        string rt;
        it = exp_q.pop_front();
        rt = (it.tag == "R6") ? "R6" : "R5";
        if (it.chk_c) chk(dout_c, it.exp_c, it.tag, "direct output");
        if (it.chk_r) chk(dout_r, it.exp_r, rt, "registered output");
        if (it.chk_k) begin
          chk(casc_c, it.exp_k, "R4", "cascade (direct unit)");
          chk(casc_r, it.exp_k, "R4", "cascade (registered unit)");
        end
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R6: reset state of the output flip-flop
    for (int i = 0; i < 3; i++) step(next_bit(), 1'b1, 0, 1'b1, "R6");
    // R1: fill the chain
    for (int i = 0; i < 40; i++) step(next_bit(), 1'b1, 0, 1'b0, "R1");
    // R1 / R7: sweep every address, including the 15/16 unit boundary
    for (int a = 0; a < TOT; a++)
      step(next_bit(), 1'b1, a, 1'b0, (a == 15 || a == 16) ? "R7" : "R1");
    for (int a = 14; a < 18; a++) step(next_bit(), 1'b1, a, 1'b0, "R7");
    // R4: cascade output is independent of the address
    for (int i = 0; i < 30; i++) step(next_bit(), 1'b1, (i * 7) % TOT, 1'b0, "R4");
    // R2: gated enable
    for (int i = 0; i < 45; i++) step(next_bit(), (i % 3) != 0, i % TOT, 1'b0, "R2");
    // R3: address change without an edge
    peek(0); peek(5); peek(15); peek(16); peek(31);
    // R5: steady address then changing address
    for (int i = 0; i < 20; i++) step(next_bit(), 1'b1, 3, 1'b0, "R5");
    for (int i = 0; i < 20; i++) step(next_bit(), 1'b1, (i * 5 + 1) % TOT, 1'b0, "R5");
    // R6: reset without enable keeps the stages, reset with enable still shifts
    step(next_bit(), 1'b0, 7, 1'b1, "R6");
    step(next_bit(), 1'b0, 7, 1'b0, "R6");
    step(next_bit(), 1'b1, 9, 1'b1, "R6");
    step(next_bit(), 1'b1, 9, 1'b0, "R6");
    step(next_bit(), 1'b1, 20, 1'b0, "R6");
    @(negedge clk); ce = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule